// File: doc/BRIEF.md
# CAN Node Status Flag Register

This block follows the fault-confinement state of a CAN node and presents it in the upper byte of a control and status register. The protocol engine supplies the transmit and receive error counters. From these the block derives a two-bit node state. It raises a sticky flag on each upward step of that state, and on the return from bus off to error active. The flag drives an interrupt, which an enable input gates.

The protocol engine also reports whether a message is being sent, whether any message is on the bus, whether an error or overload frame is in progress, and whether the node is halted. The block turns these into registered transmit and receive status bits.

A CPU port is included. A read always returns the assembled byte. A write can only clear the sticky flag. A qualifier marks reads that belong to read-modify-write bit operations; during such reads the flag bit reads as 1, so that the write-back half of the operation cannot clear the flag by accident.

Top module: `can_nsr_top`

## Requirements
- R1: The node state is encoded 00 error active, 01 warning, 10 error passive, 11 bus off. One clock after the counters change, the state becomes:
  - bus off when the transmit counter is 256 or more;
  - otherwise error passive when either counter is 128 or more;
  - otherwise warning when either counter is 96 or more;
  - otherwise error active.
  Once in bus off, the state stays there whatever the counters are, until a recovery pulse returns it to error active.
- R2: The sticky flag (read bit 2) is set in the clock in which the state changes 00→01, 01→10, 10→11 or 11→00.
- R3: No other state change sets the flag. This covers downward steps such as 01→00 or 10→01, and jumps such as 00→10.
- R4: A CPU write with bit 2 equal to 0 clears the flag one clock later. A write with bit 2 equal to 1 leaves the flag unchanged.
- R5: While the read-modify-write qualifier is high, read bit 2 is 1 whatever the flag holds. While the qualifier is low, read bit 2 shows the flag.
- R6: The status interrupt is high exactly while the flag is 1 and the interrupt enable input is 1.
- R7: The transmit status (read bit 7) is registered. It is 1 one clock after a message is being sent and no error or overload frame is in progress, and 0 otherwise.
- R8: The receive status (read bit 6) is registered. It is 1 one clock after a message is on the bus, whether the node sends it or not, provided the node is not halted and no error or overload frame is in progress. Otherwise it is 0.
- R9: The read byte is laid out as: bit 7 transmit status, bit 6 receive status, bits 5 to 3 always 0, bit 2 flag, bits 1 to 0 node state. A write never changes bits 5 to 3, 7, 6, 1 or 0.
- R10: When a flag-setting transition and a clearing write fall in the same clock, the flag ends up 1.
- R11: A synchronous active-high reset gives state 00, flag 0, and transmit and receive status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_cnt | input | 9 | Transmit error counter |
| rx_err_cnt | input | 9 | Receive error counter |
| busoff_recover | input | 1 | One-clock pulse that ends bus off |
| tx_msg_active | input | 1 | Node is sending a message |
| bus_msg_active | input | 1 | A message is on the bus |
| err_ovl_frame | input | 1 | Error or overload frame in progress |
| halted | input | 1 | Bus operation halted |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_rmw | input | 1 | Current read belongs to a read-modify-write |
| irq_en | input | 1 | Node status interrupt enable |
| rd_data | output | 8 | CPU read data |
| node_status | output | 2 | Current node state |
| tx_status | output | 1 | Transmit status |
| rx_status | output | 1 | Receive status |
| trans_flag | output | 1 | Sticky transition flag |
| status_irq | output | 1 | Node status interrupt |

## Verification
The flag can receive a state-driven set and a software clear in the same clock. The bench provokes this by changing the counters across a threshold and strobing a clearing write on the same clock edge, both when the flag starts at 0 and when it is already 1. The bench passes only if the flag reads 1 afterwards. A table of counter steps walks the upward, downward and skipped transitions, each followed by a clear, so that every step is judged on its own.

// File: rtl/can_nsr_pkg.sv
`timescale 1ns/1ps
package can_nsr_pkg;

    localparam int CNT_W_DEF    = 9;
    localparam int WARN_LIM_DEF = 96;
    localparam int PASS_LIM_DEF = 128;
    localparam int BOFF_LIM_DEF = 256;

    typedef enum logic [1:0] {
        NS_ACTIVE  = 2'b00,
        NS_WARN    = 2'b01,
        NS_PASSIVE = 2'b10,
        NS_BUSOFF  = 2'b11
    } node_state_e;

    typedef struct packed {
        logic       ts;
        logic       rs;
        logic [2:0] rsvd;
        logic       nt;
        logic [1:0] ns;
    } csr_hi_t;

    // A flagged step is one that moves to the next code, wrapping 11 to 00.
    function automatic logic is_flag_step(node_state_e from_s, node_state_e to_s);
        logic [1:0] nxt;
        nxt = from_s + 2'd1;
        return to_s == node_state_e'(nxt);
    endfunction

endpackage

// File: rtl/nsr_state_track.sv
`timescale 1ns/1ps
module nsr_state_track
    import can_nsr_pkg::*;
#(
    parameter int CNT_W    = CNT_W_DEF,
    parameter int WARN_LIM = WARN_LIM_DEF,
    parameter int PASS_LIM = PASS_LIM_DEF,
    parameter int BOFF_LIM = BOFF_LIM_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    input  logic             recover,
    output node_state_e      state_q,
    output logic             step_set
);

    node_state_e state_d;
    logic        tec_boff, any_pass, any_warn;

    always_comb begin
        tec_boff = int'(tec) >= BOFF_LIM;
        any_pass = (int'(tec) >= PASS_LIM) || (int'(rec) >= PASS_LIM);
        any_warn = (int'(tec) >= WARN_LIM) || (int'(rec) >= WARN_LIM);
    end

    always_comb begin
        if (state_q == NS_BUSOFF) begin
            state_d = recover ? NS_ACTIVE : NS_BUSOFF;
        end else if (tec_boff) begin
            state_d = NS_BUSOFF;
        end else if (any_pass) begin
            state_d = NS_PASSIVE;
        end else if (any_warn) begin
            state_d = NS_WARN;
        end else begin
            state_d = NS_ACTIVE;
        end
    end

    assign step_set = !rst && is_flag_step(state_q, state_d);

    always_ff @(posedge clk) begin
        if (rst) state_q <= NS_ACTIVE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/nsr_sticky_flag.sv
`timescale 1ns/1ps
module nsr_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

endmodule

// File: rtl/nsr_bus_status.sv
`timescale 1ns/1ps
module nsr_bus_status (
    input  logic clk,
    input  logic rst,
    input  logic tx_msg,
    input  logic bus_msg,
    input  logic err_ovl,
    input  logic halted,
    output logic ts_q,
    output logic rs_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q <= 1'b0;
            rs_q <= 1'b0;
        end else begin
            ts_q <= tx_msg && !err_ovl;
            rs_q <= bus_msg && !err_ovl && !halted;
        end
    end

endmodule

// File: rtl/can_nsr_top.sv
`timescale 1ns/1ps
module can_nsr_top
    import can_nsr_pkg::*;
#(
    parameter int CNT_W    = CNT_W_DEF,
    parameter int WARN_LIM = WARN_LIM_DEF,
    parameter int PASS_LIM = PASS_LIM_DEF,
    parameter int BOFF_LIM = BOFF_LIM_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_err_cnt,
    input  logic [CNT_W-1:0] rx_err_cnt,
    input  logic             busoff_recover,
    input  logic             tx_msg_active,
    input  logic             bus_msg_active,
    input  logic             err_ovl_frame,
    input  logic             halted,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_rmw,
    input  logic             irq_en,
    output logic [7:0]       rd_data,
    output logic [1:0]       node_status,
    output logic             tx_status,
    output logic             rx_status,
    output logic             trans_flag,
    output logic             status_irq
);

    node_state_e state_q;
    logic        step_set;
    logic        sw_clear;
    csr_hi_t     wr_view;
    csr_hi_t     rd_view;

    assign wr_view  = csr_hi_t'(wr_data);
    assign sw_clear = wr_en && !wr_view.nt;

    nsr_state_track #(
        .CNT_W   (CNT_W),
        .WARN_LIM(WARN_LIM),
        .PASS_LIM(PASS_LIM),
        .BOFF_LIM(BOFF_LIM)
    ) i_track (
        .clk     (clk),
        .rst     (rst),
        .tec     (tx_err_cnt),
        .rec     (rx_err_cnt),
        .recover (busoff_recover),
        .state_q (state_q),
        .step_set(step_set)
    );

    nsr_sticky_flag i_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (step_set),
        .clr_i (sw_clear),
        .flag_o(trans_flag)
    );

    nsr_bus_status i_bus (
        .clk    (clk),
        .rst    (rst),
        .tx_msg (tx_msg_active),
        .bus_msg(bus_msg_active),
        .err_ovl(err_ovl_frame),
        .halted (halted),
        .ts_q   (tx_status),
        .rs_q   (rx_status)
    );

    always_comb begin
        rd_view.ts   = tx_status;
        rd_view.rs   = rx_status;
        rd_view.rsvd = 3'b000;
        rd_view.nt   = trans_flag || rd_rmw;
        rd_view.ns   = state_q;
    end

    assign rd_data     = rd_view;
    assign node_status = state_q;
    assign status_irq  = trans_flag && irq_en;

endmodule

// File: rtl/can_nsr_chk.sv
`timescale 1ns/1ps
module can_nsr_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] tx_err_cnt,
    input logic [CNT_W-1:0] rx_err_cnt,
    input logic             busoff_recover,
    input logic             tx_msg_active,
    input logic             bus_msg_active,
    input logic             err_ovl_frame,
    input logic             halted,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             irq_en,
    input logic [7:0]       rd_data,
    input logic [1:0]       node_status,
    input logic             tx_status,
    input logic             rx_status,
    input logic             trans_flag,
    input logic             status_irq,
    input logic             step_set
);

    // R1: bus off is held until a recovery pulse
    a_r1_busoff_hold: assert property (@(posedge clk) disable iff (rst)
        (node_status == 2'b11 && !busoff_recover) |=> node_status == 2'b11);

    // R1: a recovery pulse in bus off returns to error active
    a_r1_recover: assert property (@(posedge clk) disable iff (rst)
        (node_status == 2'b11 && busoff_recover) |=> node_status == 2'b00);

    // R3: a step down from warning to active does not raise the flag
    a_r3_no_down_set: assert property (@(posedge clk) disable iff (rst)
        (node_status == 2'b01 && !trans_flag && tx_err_cnt < 9'd96 && rx_err_cnt < 9'd96)
        |=> !trans_flag);

    // R10: a set request wins over any clear in the same clock
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        step_set |=> trans_flag);

    // R4: a write can never raise the flag
    a_r4_write_no_set: assert property (@(posedge clk) disable iff (rst)
        (!trans_flag && !step_set && wr_en) |=> !trans_flag);

    // R6: interrupt only with flag and enable
    a_r6_irq_gate: assert property (@(posedge clk) disable iff (rst)
        status_irq |-> (trans_flag && irq_en));

    // R7: transmit status follows a clean message send
    a_r7_ts: assert property (@(posedge clk) disable iff (rst)
        tx_status |-> $past(tx_msg_active && !err_ovl_frame));

    // R8: receive status follows bus activity while not halted
    a_r8_rs: assert property (@(posedge clk) disable iff (rst)
        rx_status |-> $past(bus_msg_active && !err_ovl_frame && !halted));

    // R9: reserved read bits stay zero after any write
    a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data != 8'h00) |=> rd_data[5:3] == 3'b000);

endmodule

bind can_nsr_top can_nsr_chk #(.CNT_W(CNT_W)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .tx_err_cnt    (tx_err_cnt),
    .rx_err_cnt    (rx_err_cnt),
    .busoff_recover(busoff_recover),
    .tx_msg_active (tx_msg_active),
    .bus_msg_active(bus_msg_active),
    .err_ovl_frame (err_ovl_frame),
    .halted        (halted),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .irq_en        (irq_en),
    .rd_data       (rd_data),
    .node_status   (node_status),
    .tx_status     (tx_status),
    .rx_status     (rx_status),
    .trans_flag    (trans_flag),
    .status_irq    (status_irq),
    .step_set      (step_set)
);

// File: tb/test_can_nsr_top.sv
`timescale 1ns/1ps
module test_can_nsr_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] tx_err_cnt = '0;
    logic [8:0] rx_err_cnt = '0;
    logic       busoff_recover = 1'b0;
    logic       tx_msg_active = 1'b0;
    logic       bus_msg_active = 1'b0;
    logic       err_ovl_frame = 1'b0;
    logic       halted = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_rmw = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] node_status;
    logic       tx_status, rx_status, trans_flag, status_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    can_nsr_top i_can_nsr_top (
        .clk(clk), .rst(rst),
        .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .busoff_recover(busoff_recover),
        .tx_msg_active(tx_msg_active), .bus_msg_active(bus_msg_active),
        .err_ovl_frame(err_ovl_frame), .halted(halted),
        .wr_en(wr_en), .wr_data(wr_data), .rd_rmw(rd_rmw), .irq_en(irq_en),
        .rd_data(rd_data), .node_status(node_status),
        .tx_status(tx_status), .rx_status(rx_status),
        .trans_flag(trans_flag), .status_irq(status_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at negedge, capture on posedge, sample 1 ns later
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h00;
        tick();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // {tec[8:0], rec[8:0], recover, exp_ns[1:0], exp_flag}
    localparam int NV = 14;
    localparam logic [21:0] VEC [NV] = '{
        {9'd0,   9'd0,   1'b0, 2'b00, 1'b0},
        {9'd96,  9'd0,   1'b0, 2'b01, 1'b1},
        {9'd96,  9'd130, 1'b0, 2'b10, 1'b1},
        {9'd256, 9'd130, 1'b0, 2'b11, 1'b1},
        {9'd0,   9'd0,   1'b0, 2'b11, 1'b0},
        {9'd0,   9'd0,   1'b1, 2'b00, 1'b1},
        {9'd0,   9'd100, 1'b0, 2'b01, 1'b1},
        {9'd0,   9'd0,   1'b0, 2'b00, 1'b0},
        {9'd0,   9'd96,  1'b0, 2'b01, 1'b1},
        {9'd0,   9'd128, 1'b0, 2'b10, 1'b1},
        {9'd0,   9'd100, 1'b0, 2'b01, 1'b0},
        {9'd0,   9'd0,   1'b0, 2'b00, 1'b0},
        {9'd200, 9'd0,   1'b0, 2'b10, 1'b0},
        {9'd95,  9'd0,   1'b0, 2'b00, 1'b0}
    };

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R11 ns", node_status, 0);
        check("R11 flag", trans_flag, 0);
        check("R11 ts", tx_status, 0);
        check("R11 rs", rx_status, 0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R2 R3: table walk, flag cleared after every step
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            tx_err_cnt     = VEC[i][21:13];
            rx_err_cnt     = VEC[i][12:4];
            busoff_recover = VEC[i][3];
            tick();
            check($sformatf("R1 ns vec%0d", i), node_status, int'(VEC[i][2:1]));
            check($sformatf("R9 rd ns vec%0d", i), int'(rd_data[1:0]), int'(VEC[i][2:1]));
            check($sformatf("R2/R3 flag vec%0d", i), trans_flag, int'(VEC[i][0]));
            @(negedge clk);
            busoff_recover = 1'b0;
            clear_flag();
        end
        check("R4 clear by write0", trans_flag, 0);

        // R4: write 1 leaves flag 0, then leaves flag 1
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h04;
        tick();
        @(negedge clk);
        wr_en = 1'b0;
        check("R4 write1 no set", trans_flag, 0);
        tx_err_cnt = 9'd0; rx_err_cnt = 9'd96;
        tick();
        check("R2 set 00->01", trans_flag, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hFF;
        tick();
        @(negedge clk);
        wr_en = 1'b0;
        check("R4 write1 keeps 1", trans_flag, 1);
        check("R9 rsvd after FF write", int'(rd_data[5:3]), 0);
        check("R9 ns unchanged by write", node_status, 1);

        // R6: interrupt gating
        irq_en = 1'b0;
        #1;
        check("R6 irq disabled", status_irq, 0);
        irq_en = 1'b1;
        #1;
        check("R6 irq enabled", status_irq, 1);

        // R5: read-modify-write read
        clear_flag();
        #1;
        check("R5 normal read", int'(rd_data[2]), 0);
        check("R6 irq after clear", status_irq, 0);
        rd_rmw = 1'b1;
        #1;
        check("R5 rmw read", int'(rd_data[2]), 1);
        check("R5 rmw no irq", status_irq, 0);
        rd_rmw = 1'b0;

        // R10: set and clear in same clock, flag starting at 0
        @(negedge clk);
        rx_err_cnt = 9'd128;
        wr_en = 1'b1; wr_data = 8'h00;
        tick();
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 set wins from 0", trans_flag, 1);
        check("R10 ns passive", node_status, 2);
        // R10: flag already 1
        tx_err_cnt = 9'd300;
        wr_en = 1'b1; wr_data = 8'h00;
        tick();
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 set wins from 1", trans_flag, 1);
        check("R1 busoff tec>=256", node_status, 3);

        // R7 R8: bus status bits
        tx_msg_active = 1'b1; bus_msg_active = 1'b1;
        tick();
        check("R7 ts sending", tx_status, 1);
        check("R8 rs own msg", rx_status, 1);
        check("R9 rd ts", int'(rd_data[7]), 1);
        check("R9 rd rs", int'(rd_data[6]), 1);
        @(negedge clk);
        err_ovl_frame = 1'b1;
        tick();
        check("R7 ts err frame", tx_status, 0);
        check("R8 rs err frame", rx_status, 0);
        @(negedge clk);
        err_ovl_frame = 1'b0; tx_msg_active = 1'b0;
        tick();
        check("R7 ts receiving", tx_status, 0);
        check("R8 rs foreign msg", rx_status, 1);
        @(negedge clk);
        halted = 1'b1;
        tick();
        check("R8 rs halted", rx_status, 0);
        @(negedge clk);
        halted = 1'b0; bus_msg_active = 1'b0;
        tick();
        check("R8 rs idle", rx_status, 0);

        // R11: reset mid-run
        @(negedge clk);
        tx_msg_active = 1'b1; bus_msg_active = 1'b1;
        tick();
        @(negedge clk);
        rst = 1'b1;
        tx_err_cnt = 9'd0; rx_err_cnt = 9'd0;
        tick();
        check("R11 ns after reset", node_status, 0);
        check("R11 flag after reset", trans_flag, 0);
        check("R11 ts after reset", tx_status, 0);
        check("R11 rs after reset", rx_status, 0);
        @(negedge clk);
        rst = 1'b0; tx_msg_active = 1'b0; bus_msg_active = 1'b0;
        tick();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule